// File: doc/BRIEF.md
# Keyed Non-Stoppable Watchdog

This block is a watchdog counter that advances on a low-speed clock-enable tick and runs on the system clock. If it reaches the selected period, it raises a one-cycle internal reset request. Software cannot halt it. A low-power stop input has no effect on counting. Software keeps the system alive by writing a key byte to a clear register before the period runs out. Any other value written there is treated as a fault and requests a reset at once.

A small write port reaches two registers, picked by `wr_addr`:

- **Mode register** (`wr_addr` = 0). Bits 2:0 select the period. The first write after reset is accepted. A later write is rejected and raises a reset request. Every write to this register clears the count.
- **Clear register** (`wr_addr` = 1). Writing the key restarts the count from zero.

A two-state lock machine tracks the mode register:

- **LK_OPEN** is the state after reset.
- Transition **T_SEAL** (LK_OPEN to LK_SEALED) happens on the first mode write. It stores the select code.
- Transition **T_REJECT** (LK_SEALED to LK_SEALED) happens on any later mode write. It raises the fault.

With no mode write pending, each state holds.

Top module: `wdg_keyed`

## Requirements
- R1: The count changes only on a cycle with `lsi_tick` high or a write. With neither, the count holds.
- R2: After reset release, the count is 0, `rst_req` is 0 and `mode_val` reads 8'h1F (select code 7, the longest period).
- R3: Select code n gives a period of 2^(BASE_EXP+n) ticks. On the tick that would complete the period, the count returns to 0 and `rst_req` is 1 from that clock edge onward.
- R4: Writing 8'hAC to the clear register (`wr_addr`=1) sets the count to 0 without a reset request.
- R5: Any write to the mode register (`wr_addr`=0) sets the count to 0, whether accepted or rejected.
- R6: Bits 7:3 of a mode write are ignored. `mode_val` always reads bits 7:5 as 0, bits 4:3 as 2'b11, and bits 2:0 as the stored select code.
- R7: `stop_req` has no effect. Ticks keep advancing the count while it is high.
- R8: `rst_req` lasts one clock cycle for a single cause.
- R9: Writing any value other than 8'hAC to the clear register sets `rst_req` on the next edge and does not clear the count.
- R10: A mode write after the first one since reset sets `rst_req` on the next edge and leaves `mode_val` unchanged.
- R11: Asserting `rst_n` low returns the count, select code and lock state to their power-on values. After release, a mode write is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsi_tick | input | 1 | One-cycle enable per low-speed clock period |
| stop_req | input | 1 | Low-power stop indication; does not halt counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = clear register |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle internal reset request |
| count | output | BASE_EXP+2^SEL_W-1 | Current count value |
| mode_val | output | 8 | Mode register read value |

## Verification
The bench runs the longest default period up to the wrap tick. A design with an off-by-one limit would fire one tick early or late.

It also runs a short select code to catch a period computed from the wrong exponent.

It writes a mode value whose upper bits are all wrong. A design that stored bits 4:3 or 7:5 would then read back differently.

It checks three more faults:

- A bad key must raise the request without clearing the count. A design that confused the two clear paths would reset the count or stay silent.
- A second mode write must leave the period alone. A missing lock would let it change.
- An external reset must reopen the lock. A sticky lock would reject the first write after reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned   WDG_DATA_W    = 8;
    localparam logic [7:0]    WDG_KEY       = 8'hAC;
    localparam logic [1:0]    WDG_SRC_FIXED = 2'b11;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic mode_wr;
        logic key_ok;
        logic key_bad;
    } wr_decode_t;

endpackage

// File: rtl/wdg_wr_decode.sv
module wdg_wr_decode
    import wdg_pkg::*;
(
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [WDG_DATA_W-1:0] wr_data,
    output wr_decode_t            dec
);

    always_comb begin
        dec         = '0;
        dec.mode_wr = wr_en && !wr_addr;
        dec.key_ok  = wr_en && wr_addr && (wr_data == WDG_KEY);
        dec.key_bad = wr_en && wr_addr && (wr_data != WDG_KEY);
    end

endmodule

// File: rtl/wdg_mode_fsm.sv
module wdg_mode_fsm
    import wdg_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] sel,
    output logic             mode_clr,
    output logic             lock_fault
);

    localparam logic [SEL_W-1:0] SEL_LONGEST = '1;

    lock_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
            sel_q   <= SEL_LONGEST;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        sel_d      = sel_q;
        mode_clr   = 1'b0;
        lock_fault = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                if (mode_wr) begin          // T_SEAL
                    state_d  = LK_SEALED;
                    sel_d    = wr_sel;
                    mode_clr = 1'b1;
                end
            end
            LK_SEALED: begin
                if (mode_wr) begin          // T_REJECT
                    mode_clr   = 1'b1;
                    lock_fault = 1'b1;
                end
            end
            default: begin
                state_d = LK_OPEN;
            end
        endcase
    end

    assign sel = sel_q;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int unsigned BASE_EXP = 11,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned CW       = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    cnt,
    output logic             ovf
);

    localparam int unsigned NCODE = 1 << SEL_W;

    logic [CW-1:0] last_cnt [NCODE];
    logic [CW-1:0] cnt_q, cnt_d;

    // Terminal value per select code: BASE_EXP+g low bits set
    for (genvar g = 0; g < NCODE; g++) begin : g_limit
        assign last_cnt[g] = {CW{1'b1}} >> (NCODE - 1 - g);
    end

    always_comb begin
        ovf   = tick && !clr && (cnt_q == last_cnt[sel]);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = ovf ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_EXP = 11,
    parameter int unsigned SEL_W    = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lsi_tick,
    input  logic                               stop_req,
    input  logic                               wr_en,
    input  logic                               wr_addr,
    input  logic [WDG_DATA_W-1:0]              wr_data,
    output logic                               rst_req,
    output logic [BASE_EXP+(1<<SEL_W)-2:0]     count,
    output logic [WDG_DATA_W-1:0]              mode_val
);

    localparam int unsigned CNT_W = BASE_EXP + (1 << SEL_W) - 1;
    localparam int unsigned PAD_W = WDG_DATA_W - SEL_W - 2;

    wr_decode_t       dec;
    logic [SEL_W-1:0] sel;
    logic             mode_clr;
    logic             lock_fault;
    logic             cnt_clr;
    logic             run_tick;
    logic             ovf;
    logic             req_q;

    wdg_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dec     (dec)
    );

    wdg_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (dec.mode_wr),
        .wr_sel     (wr_data[SEL_W-1:0]),
        .sel        (sel),
        .mode_clr   (mode_clr),
        .lock_fault (lock_fault)
    );

    // The stop indication is deliberately not a gate: the tick passes
    // whatever its level.
    assign run_tick = lsi_tick & (stop_req | ~stop_req);
    assign cnt_clr  = dec.key_ok | mode_clr;

    wdg_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (run_tick),
        .clr   (cnt_clr),
        .sel   (sel),
        .cnt   (count),
        .ovf   (ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= ovf | lock_fault | dec.key_bad;
    end

    assign rst_req  = req_q;
    assign mode_val = {{PAD_W{1'b0}}, WDG_SRC_FIXED, sel};

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
    import wdg_pkg::*;
#(
    parameter int unsigned CW = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lsi_tick,
    input logic                  stop_req,
    input logic                  wr_en,
    input logic                  wr_addr,
    input logic [WDG_DATA_W-1:0] wr_data,
    input logic                  rst_req,
    input logic [CW-1:0]         count,
    input logic [WDG_DATA_W-1:0] mode_val
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  seen_q <= 1'b0;
        else if (wr_en && !wr_addr)  seen_q <= 1'b1;
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsi_tick && !wr_en) |=> (count == $past(count)));

    p_key_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_data == WDG_KEY) |=> (count == '0));

    p_mode_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (count == '0));

    p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_val[4:3] == WDG_SRC_FIXED) && (mode_val[7:5] == 3'b000));

    p_stop_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && lsi_tick && !wr_en) |=> (count != $past(count)));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> !rst_req);

    p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_data != WDG_KEY) |=> rst_req);

    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && wr_en && !wr_addr) |=> (rst_req && $stable(mode_val)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_req) && !$past(wr_en)) |-> (count == '0));

endmodule

bind wdg_keyed wdg_keyed_chk #(.CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lsi_tick (lsi_tick),
    .stop_req (stop_req),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rst_req  (rst_req),
    .count    (count),
    .mode_val (mode_val)
);

// File: tb/wdg_keyed_bench.sv
`timescale 1ns/1ps
module wdg_keyed_bench;

    localparam int unsigned BASE = 2;
    localparam int unsigned CW   = BASE + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lsi_tick = 1'b0;
    logic          stop_req = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          rst_req;
    logic [CW-1:0] count;
    logic [7:0]    mode_val;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wdg_keyed #(.BASE_EXP(BASE), .SEL_W(3)) u_wdg_keyed (
        .clk      (clk),
        .rst_n    (rst_n),
        .lsi_tick (lsi_tick),
        .stop_req (stop_req),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rst_req  (rst_req),
        .count    (count),
        .mode_val (mode_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs set just after a falling edge, held through one rising edge.
    task automatic cyc(input logic t, input logic we, input logic a, input logic [7:0] d);
        lsi_tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        lsi_tick = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 count", int'(count), 0);
        chk("R2 rst_req", int'(rst_req), 0);
        chk("R2 mode_val", int'(mode_val), 8'h1F);
    endtask

    task automatic t_tick_only();
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R1 idle hold", int'(count), 0);
        ticks(3);
        chk("R1 three ticks", int'(count), 3);
    endtask

    task automatic t_default_period();
        cyc(1'b0, 1'b1, 1'b1, 8'hAC);
        ticks(511);
        chk("R3 before wrap count", int'(count), 511);
        chk("R3 before wrap req", int'(rst_req), 0);
        ticks(1);
        chk("R3 wrap req", int'(rst_req), 1);
        chk("R3 wrap count", int'(count), 0);
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R8 pulse ends", int'(rst_req), 0);
    endtask

    task automatic t_stop();
        stop_req = 1'b1;
        ticks(4);
        chk("R7 counts in stop", int'(count), 4);
        stop_req = 1'b0;
    endtask

    task automatic t_key();
        cyc(1'b0, 1'b1, 1'b1, 8'hAC);
        chk("R4 key clears", int'(count), 0);
        chk("R4 no req", int'(rst_req), 0);
        ticks(5);
        cyc(1'b0, 1'b1, 1'b1, 8'h55);
        chk("R9 bad key req", int'(rst_req), 1);
        chk("R9 count kept", int'(count), 5);
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R8 bad key pulse ends", int'(rst_req), 0);
    endtask

    task automatic t_mode();
        ticks(3);
        cyc(1'b0, 1'b1, 1'b0, 8'hE2);
        chk("R5 mode clears", int'(count), 0);
        chk("R6 upper bits ignored", int'(mode_val), 8'h1A);
        chk("R5 no req", int'(rst_req), 0);
        ticks(15);
        chk("R3 code2 no req", int'(rst_req), 0);
        ticks(1);
        chk("R3 code2 req", int'(rst_req), 1);
        chk("R3 code2 wrap", int'(count), 0);
    endtask

    task automatic t_lock();
        ticks(3);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R10 second write req", int'(rst_req), 1);
        chk("R10 mode kept", int'(mode_val), 8'h1A);
        chk("R5 rejected write clears", int'(count), 0);
    endtask

    task automatic t_ext_reset();
        ticks(2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 count reset", int'(count), 0);
        chk("R11 mode reset", int'(mode_val), 8'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1'b0, 1'b1, 1'b0, 8'h08);
        chk("R11 write accepted", int'(mode_val), 8'h18);
        chk("R11 no fault", int'(rst_req), 0);
        ticks(3);
        chk("R3 code0 no req", int'(rst_req), 0);
        ticks(1);
        chk("R3 code0 req", int'(rst_req), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tick_only();
        t_default_period();
        t_stop();
        t_key();
        t_mode();
        t_lock();
        t_ext_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule